// File: doc/BRIEF.md
# Sampled Quadrature Frequency Discriminator

This block decides whether a divided oscillator clock runs slower than, faster than, or at the same rate as a reference clock. Two copies of the reference are supplied, one in phase and one shifted by a quarter period. Each rising edge of the divided clock samples both reference levels. The new in-phase sample is also compared with the in-phase sample taken on the edge before. The quadrant these samples fall in, and the direction in which the in-phase level moved, show which signal is gaining phase. Four three-input product terms decode that information into a set request and a reset request. A JK-style state register keeps the last verdict.

If neither request fires within a programmable number of reference periods, the verdict falls back to "same frequency". All three inputs are asynchronous to the fast system clock. They pass through synchronizer chains, and all edge detection runs in the system clock domain. A synchronous clear returns the block to its idle state. An outer search loop can use the clear before each trial setting.

Top module: `sampled_freq_discriminator`

## Requirements
- R1: After reset or a cycle with `clr` high, `verdict` reads 00 (same).
- R2: A rising edge on `div_clk` changes `verdict` at the third system-clock rising edge after the edge is presented, and not at the second. The block uses two synchronizer stages plus one edge-detect register.
- R3: On a sampled `div_clk` rising edge, let A be the synchronized `ref_i` level, B the synchronized `ref_q` level and C the A from the previous sampled edge. When A differs from B and C equals A (the terms A·B'·C or A'·B·C'), `verdict` becomes 01 (divided clock slower).
- R4: On a sampled edge where A differs from B and C differs from A (the terms A'·B·C or A·B'·C'), `verdict` becomes 10 (divided clock faster).
- R5: On a sampled edge where A equals B, `verdict` keeps its previous value.
- R6: The first sampled `div_clk` edge after reset or clear only records C and leaves `verdict` unchanged.
- R7: While `verdict` is 01 or 10, it returns to 00 on the Nth synchronized rising edge of `ref_i` counted since the last set or reset request, where N is `win_len`. Every set or reset request restarts that count from zero.
- R8: A `win_len` of 0 selects a window of 16 reference edges.
- R9: A clear also restarts the window count. After a clear, a later verdict times out only after a full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than all monitored signals |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of verdict, window count and sample history |
| ref_i | input | 1 | Reference clock, in-phase copy (asynchronous) |
| ref_q | input | 1 | Reference clock shifted by a quarter period (asynchronous) |
| div_clk | input | 1 | Divided oscillator clock (asynchronous) |
| win_len | input | 8 | Timeout window in reference rising edges; 0 selects 16 |
| verdict | output | 2 | 00 same, 01 divided slower, 10 divided faster |

## Verification
The bench sweeps all eight (A, B, C) combinations from each of the three prior verdicts. A swapped or mis-polarised product term would therefore flip slower and faster for one quadrant. A decoder that ignored A equal to B would disturb a held verdict. Every edge is checked one cycle before and one cycle after its expected update, which catches any missing or extra synchronizer stage. The window is checked at N-1 and N edges, after a restart by a new request and after a clear. The zero-means-default setting is checked at 15 and 16 edges. A counter that was not restarted, or that was off by one, times out one edge early or late. A decoder that trusted a stale C after a clear would produce a verdict on the first edge.

// File: rtl/fd_pkg.sv
// Shared types for the sampled frequency discriminator.
// Assumes a two-bit verdict code that downstream search logic decodes.
package fd_pkg;

    typedef enum logic [1:0] {
        VERDICT_SAME = 2'b00,
        VERDICT_SLOW = 2'b01,
        VERDICT_FAST = 2'b10
    } verdict_t;

endpackage

// File: rtl/fd_sync.sv
// Multi-bit synchronizer: each bit gets its own chain of STAGES flops.
// Assumes every input bit is an independent asynchronous level and
// that STAGES is at least 2.
module fd_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level into the chain, oldest stage at the top.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end

        assign dout[g] = chain[LAST];
    end

endmodule

// File: rtl/fd_quad_decode.sv
// Samples the reference phases on divided-clock rising edges and decodes
// the four three-signal product terms into set (slower) and reset (faster)
// requests. The first sample after reset or clear only seeds history.
// Assumes all inputs are already synchronized to clk.
module fd_quad_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic div_lvl,
    input  logic ip_lvl,
    input  logic qp_lvl,
    output logic set_req,
    output logic rst_req
);

    logic div_prev;
    logic hist_q;
    logic seen_q;
    logic sample;
    logic a_s, b_s, c_s;
    logic [3:0] terms;

    assign sample = div_lvl & ~div_prev;
    assign a_s    = ip_lvl;
    assign b_s    = qp_lvl;
    assign c_s    = hist_q;

    // Product terms: [0],[1] request "slower", [2],[3] request "faster".
    always_comb begin
        terms[0] =  a_s & ~b_s &  c_s;
        terms[1] = ~a_s &  b_s & ~c_s;
        terms[2] =  a_s & ~b_s & ~c_s;
        terms[3] = ~a_s &  b_s &  c_s;
    end

    assign set_req = sample & seen_q & ~clr & (terms[0] | terms[1]);
    assign rst_req = sample & seen_q & ~clr & (terms[2] | terms[3]);

    // Track the divided-clock level for edge detection, independent of clear.
    always_ff @(posedge clk) begin
        if (!rst_n) div_prev <= 1'b0;
        else        div_prev <= div_lvl;
    end

    // Keep the previous in-phase sample and whether one has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (sample) begin
            hist_q <= a_s;
            seen_q <= 1'b1;
        end
    end

    // R3/R4: set and reset requests never fire together.
    assert_requests_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_req && rst_req));

    // R6: the cycle after a clear can never produce a request.
    assert_clear_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !(set_req || rst_req));

    // R2: a request only follows a registered rise of the divided clock.
    assert_request_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req || rst_req) |-> (div_lvl && !div_prev));

endmodule

// File: rtl/fd_window_timer.sv
// Counts synchronized reference rising edges while a slower/faster verdict
// is held and flags expiry when the programmed window is reached.
// Assumes win_len is changed only while the verdict is "same".
module fd_window_timer #(
    parameter int WIN_W          = 8,
    parameter int DEFAULT_WINDOW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ref_lvl,
    input  logic             restart,
    input  logic             armed,
    input  logic [WIN_W-1:0] win_len,
    output logic             expire
);

    localparam logic [WIN_W-1:0] DEF_LIMIT = WIN_W'(DEFAULT_WINDOW);

    logic             ref_prev;
    logic             tick;
    logic [WIN_W-1:0] cnt_q;
    logic [WIN_W-1:0] limit;
    logic [WIN_W:0]   cnt_inc;

    assign tick    = ref_lvl & ~ref_prev;
    assign limit   = (win_len == '0) ? DEF_LIMIT : win_len;
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign expire  = armed & tick & ~restart & ~clr & (cnt_inc >= {1'b0, limit});

    // Remember the reference level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_prev <= 1'b0;
        else        ref_prev <= ref_lvl;
    end

    // Window counter: restart on clear, request, expiry or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (clr || restart || expire || !armed)  cnt_q <= '0;
        else if (tick)                                cnt_q <= cnt_inc[WIN_W-1:0];
    end

    // R7: an expiry leaves the counter empty for the next window.
    assert_expire_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

    // R9: a clear leaves the counter empty.
    assert_clear_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/fd_verdict_reg.sv
// JK-style verdict register: set request -> slower, reset request ->
// faster, window expiry -> same. Clear has top priority.
// Assumes set and reset requests are mutually exclusive.
module fd_verdict_reg
    import fd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     set_req,
    input  logic     rst_req,
    input  logic     expire,
    output verdict_t state,
    output logic     armed
);

    assign armed = (state != VERDICT_SAME);

    // Update the held verdict by priority: clear, requests, expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  state <= VERDICT_SAME;
        else if (set_req)   state <= VERDICT_SLOW;
        else if (rst_req)   state <= VERDICT_FAST;
        else if (expire)    state <= VERDICT_SAME;
    end

    assert_clear_same_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == VERDICT_SAME));

    assert_set_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr) |=> (state == VERDICT_SLOW));

    assert_reset_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !clr) |=> (state == VERDICT_FAST));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set_req && !rst_req && !expire) |=> $stable(state));

    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'b11);

endmodule

// File: rtl/sampled_freq_discriminator.sv
// Top level: synchronizes the reference phases and divided clock, decodes
// quadrant transitions into a held slower/faster verdict and times out
// to "same" when no transition is decoded within the window.
// Assumes clk is several times faster than every monitored signal.
module sampled_freq_discriminator
    import fd_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int WIN_W          = 8,
    parameter int DEFAULT_WINDOW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ref_i,
    input  logic             ref_q,
    input  logic             div_clk,
    input  logic [WIN_W-1:0] win_len,
    output logic [1:0]       verdict
);

    localparam int N_IN = 3;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] sync_in;
    logic            set_req, rst_req, expire, armed;
    verdict_t        state;

    assign raw_in = {div_clk, ref_q, ref_i};

    fd_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_IN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_in)
    );

    fd_quad_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .div_lvl (sync_in[2]),
        .ip_lvl  (sync_in[0]),
        .qp_lvl  (sync_in[1]),
        .set_req (set_req),
        .rst_req (rst_req)
    );

    fd_window_timer #(.WIN_W(WIN_W), .DEFAULT_WINDOW(DEFAULT_WINDOW)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ref_lvl (sync_in[0]),
        .restart (set_req | rst_req),
        .armed   (armed),
        .win_len (win_len),
        .expire  (expire)
    );

    fd_verdict_reg u_verdict (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .set_req (set_req),
        .rst_req (rst_req),
        .expire  (expire),
        .state   (state),
        .armed   (armed)
    );

    assign verdict = state;

endmodule

// File: tb/tb_sampled_freq_discriminator.sv
// Bench: near-exhaustive sweep of sample combinations and prior verdicts,
// plus window, default-window and clear-restart scenarios. Expected values
// come from an arithmetic model of the requirements.
module tb_sampled_freq_discriminator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       ref_i = 1'b0;
    logic       ref_q = 1'b0;
    logic       div_clk = 1'b0;
    logic [7:0] win_len = 8'd0;
    logic [1:0] verdict;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state
    logic [1:0] m_state = 2'b00;
    bit         m_seen = 1'b0;
    bit         m_c = 1'b0;
    int         m_cnt = 0;

    always #10 clk = ~clk;

    sampled_freq_discriminator dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ref_i(ref_i), .ref_q(ref_q),
        .div_clk(div_clk), .win_len(win_len), .verdict(verdict)
    );

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: verdict=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int cur_limit();
        return (win_len == 8'd0) ? 16 : int'(win_len);
    endfunction

    // Model one synchronized rising edge of ref_i (R7, R8).
    task automatic model_tick();
        if (m_state != 2'b00) begin
            m_cnt++;
            if (m_cnt >= cur_limit()) begin
                m_state = 2'b00;
                m_cnt = 0;
            end
        end
    endtask

    task automatic do_clr();
        @(negedge clk); clr = 1'b1;
        @(posedge clk);
        @(negedge clk); clr = 1'b0;
        m_state = 2'b00; m_seen = 1'b0; m_cnt = 0;
        check(verdict, 2'b00, "R1 clear");
    endtask

    // Present reference levels a,b then one divided-clock rising edge.
    task automatic do_edge(input bit a, input bit b);
        logic [1:0] exp;
        string tag;
        @(negedge clk);
        if (a && !ref_i) model_tick();
        ref_i = a; ref_q = b;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(verdict, m_state, "R7 reference edge before sample");
        if (!m_seen)          begin exp = m_state; tag = "R6 first sample"; end
        else if (a == b)      begin exp = m_state; tag = "R5 equal phases"; end
        else if (m_c == a)    begin exp = 2'b01;   tag = "R3 slower";       end
        else                  begin exp = 2'b10;   tag = "R4 faster";       end
        div_clk = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(verdict, m_state, "R2 no change at second edge");
        @(posedge clk);
        @(negedge clk);
        check(verdict, exp, tag);
        if (m_seen && a != b) m_cnt = 0;
        m_state = exp; m_c = a; m_seen = 1'b1;
        div_clk = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic ref_low();
        @(negedge clk); ref_i = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // One ref_i pulse; assumes ref_i is low on entry.
    task automatic pulse_ref(input string req);
        @(negedge clk); ref_i = 1'b1;
        model_tick();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(verdict, m_state, req);
        ref_i = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: verdict=%b expected=completion", verdict);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(verdict, 2'b00, "R1 reset");
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // Sweep: prior verdict x every (A,B,C) combination.
        win_len = 8'd255;
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 2; c++) begin
                for (int ab = 0; ab < 4; ab++) begin
                    do_clr();
                    if (p == 0) begin
                        do_edge(c[0], ~c[0]);
                    end else if (p == 1) begin
                        do_edge(c[0], 1'b0);
                        do_edge(c[0], ~c[0]);
                    end else begin
                        do_edge(~c[0], 1'b0);
                        do_edge(c[0], ~c[0]);
                    end
                    do_edge(ab[1], ab[0]);
                end
            end
        end

        // R7: window of 5, then restart by a new request.
        do_clr();
        win_len = 8'd5;
        do_edge(1'b1, 1'b1);
        do_edge(1'b1, 1'b0);
        check(verdict, 2'b01, "R3 window setup");
        ref_low();
        for (int i = 0; i < 4; i++) pulse_ref("R7 within window");
        pulse_ref("R7 window expiry");
        check(verdict, 2'b00, "R7 expired to same");
        do_edge(1'b1, 1'b0);
        ref_low();
        for (int i = 0; i < 3; i++) pulse_ref("R7 count before restart");
        do_edge(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) pulse_ref("R7 restarted count");
        check(verdict, 2'b10, "R7 restart kept verdict");
        pulse_ref("R7 restarted count");
        pulse_ref("R7 restarted expiry");
        check(verdict, 2'b00, "R7 restarted expiry");

        // R9: clear mid-window restarts the count.
        do_clr();
        do_edge(1'b0, 1'b0);
        do_edge(1'b1, 1'b0);
        ref_low();
        for (int i = 0; i < 3; i++) pulse_ref("R9 before clear");
        do_clr();
        do_edge(1'b1, 1'b1);
        do_edge(1'b1, 1'b0);
        ref_low();
        for (int i = 0; i < 4; i++) pulse_ref("R9 full window after clear");
        check(verdict, 2'b01, "R9 no early expiry");
        pulse_ref("R9 expiry after clear");
        check(verdict, 2'b00, "R9 expiry after clear");

        // R8: zero selects 16.
        do_clr();
        win_len = 8'd0;
        do_edge(1'b0, 1'b1);
        do_edge(1'b1, 1'b0);
        check(verdict, 2'b10, "R4 default window setup");
        ref_low();
        for (int i = 0; i < 15; i++) pulse_ref("R8 default window");
        check(verdict, 2'b10, "R8 held at 15 edges");
        pulse_ref("R8 default expiry");
        check(verdict, 2'b00, "R8 expired at 16 edges");

        // R7: window of one.
        do_clr();
        win_len = 8'd1;
        do_edge(1'b0, 1'b0);
        do_edge(1'b0, 1'b1);
        ref_low();
        pulse_ref("R7 single-edge window");
        check(verdict, 2'b00, "R7 single-edge window");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule